// File: doc/BRIEF.md
# ALU Control Decoder and Result Steering

This block is the control stage of a 16-bit ALU that is split into three execution units: an arithmetic unit, a logic unit and a shift/rotate unit. A single mode bit and a 3-bit opcode come in. The block decodes this pair into the controls each unit needs. For the arithmetic unit it produces the sub-unit select. For the shifter it produces a direction bit and a type bit. It also produces a two-bit result-multiplexer select and a carry-out enable. The opcode is forwarded unchanged to all three units.

The block also contains the result multiplexer and the carry gate that these controls drive. The three unit results and the raw arithmetic carry come in as inputs. The block returns the ALU result and the ALU carry-out. It has no clock and no state, and every output settles within the same evaluation as its inputs.

Top module: `alu_ctrl_decoder`

## Requirements
- R1: `arith_opc_o`, `logic_opc_o` and `shift_opc_o` each equal `opcode_i` for every input combination.
- R2: With `mode_i`=0, the opcodes 000 to 111 select, in order, NOR, NAND, OR, AND, XOR, XNOR, NOT A and NOT B. In this mode `res_sel_o`=01 (logic unit), `cout_en_o`=0, `shift_dir_o`=0 and `shift_rot_o`=0.
- R3: With `mode_i`=1 and `opcode_i[2]`=0, `res_sel_o`=00 (arithmetic unit) and `cout_en_o`=1. In this case `arith_sel_o`=`opcode_i[1:0]`, where 00 is add, 01 is subtract (A-B), 10 is increment A and 11 is pass A.
- R4: With `mode_i`=1 and `opcode_i[2]`=1, `res_sel_o`=10 (shifter) and `cout_en_o`=0. In this case `shift_dir_o`=`opcode_i[0]` (0 left, 1 right) and `shift_rot_o`=`opcode_i[1]` (0 shift, 1 rotate). The four opcodes therefore give 100 shift left, 101 shift right, 110 rotate left and 111 rotate right.
- R5: `alu_cout_o` equals `arith_cout_i` when `cout_en_o`=1 and is 0 otherwise, whatever the raw carry is.
- R6: `alu_res_o` equals the result of the unit named by `res_sel_o`: `arith_res_i` for 00, `logic_res_i` for 01 and `shift_res_i` for 10.
- R7: `arith_sel_o` is 00 whenever the arithmetic unit is not selected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| mode_i | input | 1 | 0 = logic operations, 1 = arithmetic/shift operations |
| opcode_i | input | 3 | Operation code |
| arith_res_i | input | 16 | Result from arithmetic unit |
| logic_res_i | input | 16 | Result from logic unit |
| shift_res_i | input | 16 | Result from shift/rotate unit |
| arith_cout_i | input | 1 | Raw carry from arithmetic unit |
| arith_opc_o | output | 3 | Opcode forwarded to arithmetic unit |
| logic_opc_o | output | 3 | Opcode forwarded to logic unit |
| shift_opc_o | output | 3 | Opcode forwarded to shift unit |
| arith_sel_o | output | 2 | Arithmetic sub-unit select |
| res_sel_o | output | 2 | Result multiplexer select |
| cout_en_o | output | 1 | Carry-out enable |
| shift_dir_o | output | 1 | Shift direction, 0 left, 1 right |
| shift_rot_o | output | 1 | Shift type, 0 shift, 1 rotate |
| alu_res_o | output | 16 | ALU result |
| alu_cout_o | output | 1 | Gated ALU carry-out |

## Verification
The bench feeds the block from behavioural unit models. These models keep computing add, subtract or increment carries even during shift and logic opcodes, so an overflowing operand pair such as FFFF plus 1 exposes a carry gate that leaks into non-arithmetic results. All sixteen mode/opcode pairs are swept under several operand patterns. A swapped direction or type bit then shows up as a left shift where a right rotate was wanted. A mode bit that is decoded wrongly routes a logic result where an arithmetic one belongs. The bench also checks that the arithmetic select and the shifter bits rest at zero outside their own operations, which catches a decoder that leaves stale controls asserted.

// File: rtl/alu_ctrl_decoder.sv
module alu_ctrl_decoder #(
  parameter int WIDTH = 16,
  parameter int OPC_W = 3
) (
  input  logic             mode_i,
  input  logic [OPC_W-1:0] opcode_i,
  input  logic [WIDTH-1:0] arith_res_i,
  input  logic [WIDTH-1:0] logic_res_i,
  input  logic [WIDTH-1:0] shift_res_i,
  input  logic             arith_cout_i,
  output logic [OPC_W-1:0] arith_opc_o,
  output logic [OPC_W-1:0] logic_opc_o,
  output logic [OPC_W-1:0] shift_opc_o,
  output logic [1:0]       arith_sel_o,
  output logic [1:0]       res_sel_o,
  output logic             cout_en_o,
  output logic             shift_dir_o,
  output logic             shift_rot_o,
  output logic [WIDTH-1:0] alu_res_o,
  output logic             alu_cout_o
);
  localparam logic [1:0] SEL_ARITH = 2'b00;
  localparam logic [1:0] SEL_LOGIC = 2'b01;
  localparam logic [1:0] SEL_SHIFT = 2'b10;

  assign arith_opc_o = opcode_i;
  assign logic_opc_o = opcode_i;
  assign shift_opc_o = opcode_i;

  always_comb begin
    res_sel_o   = SEL_LOGIC;
    arith_sel_o = 2'b00;
    cout_en_o   = 1'b0;
    shift_dir_o = 1'b0;
    shift_rot_o = 1'b0;
    if (mode_i) begin
      if (!opcode_i[OPC_W-1]) begin
        res_sel_o   = SEL_ARITH;
        cout_en_o   = 1'b1;
        arith_sel_o = opcode_i[1:0];
      end else begin
        res_sel_o   = SEL_SHIFT;
        shift_dir_o = opcode_i[0];
        shift_rot_o = opcode_i[1];
      end
    end
  end

  always_comb begin
    case (res_sel_o)
      SEL_ARITH: alu_res_o = arith_res_i;
      SEL_LOGIC: alu_res_o = logic_res_i;
      SEL_SHIFT: alu_res_o = shift_res_i;
      default:   alu_res_o = '0;
    endcase
  end

  assign alu_cout_o = arith_cout_i & cout_en_o;
endmodule

// File: rtl/alu_ctrl_decoder_chk.sv
module alu_ctrl_decoder_chk #(
  parameter int WIDTH = 16,
  parameter int OPC_W = 3
) (
  input logic             mode_i,
  input logic [OPC_W-1:0] opcode_i,
  input logic [WIDTH-1:0] arith_res_i,
  input logic [WIDTH-1:0] logic_res_i,
  input logic [WIDTH-1:0] shift_res_i,
  input logic             arith_cout_i,
  input logic [OPC_W-1:0] arith_opc_o,
  input logic [OPC_W-1:0] logic_opc_o,
  input logic [OPC_W-1:0] shift_opc_o,
  input logic [1:0]       arith_sel_o,
  input logic [1:0]       res_sel_o,
  input logic             cout_en_o,
  input logic             shift_dir_o,
  input logic             shift_rot_o,
  input logic [WIDTH-1:0] alu_res_o,
  input logic             alu_cout_o
);
  always_comb begin
    a_r1_opcode_fwd: assert (arith_opc_o == opcode_i && logic_opc_o == opcode_i
                             && shift_opc_o == opcode_i);
    if (!mode_i)
      a_r2_logic_ctrl: assert (res_sel_o == 2'b01 && !cout_en_o && !shift_dir_o && !shift_rot_o);
    if (mode_i && !opcode_i[OPC_W-1])
      a_r3_arith_ctrl: assert (res_sel_o == 2'b00 && cout_en_o && arith_sel_o == opcode_i[1:0]);
    if (mode_i && opcode_i[OPC_W-1])
      a_r4_shift_ctrl: assert (res_sel_o == 2'b10 && !cout_en_o && shift_dir_o == opcode_i[0]
                               && shift_rot_o == opcode_i[1]);
    a_r5_cout_gate: assert (alu_cout_o == (cout_en_o & arith_cout_i));
    if (res_sel_o == 2'b01)
      a_r6_logic_route: assert (alu_res_o == logic_res_i);
    if (!(mode_i && !opcode_i[OPC_W-1]))
      a_r7_arith_sel_idle: assert (arith_sel_o == 2'b00);
  end
endmodule

bind alu_ctrl_decoder alu_ctrl_decoder_chk #(.WIDTH(WIDTH), .OPC_W(OPC_W)) chk_i (.*);

// File: tb/alu_ctrl_decoder_tb_top.sv
module alu_ctrl_decoder_tb_top;
  localparam int W = 16;

  typedef struct {
    logic [2:0]   opc;
    logic [1:0]   asel;
    logic [1:0]   rsel;
    logic         cen;
    logic         dir;
    logic         rot;
    logic [W-1:0] res;
    logic         cout;
  } exp_t;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #5 clk = ~clk;

  logic         mode;
  logic [2:0]   opc;
  logic [W-1:0] a, b;
  logic [W-1:0] ar_res, lg_res, sh_res;
  logic         ar_cout;
  logic [2:0]   ao, lo, so;
  logic [1:0]   asel, rsel;
  logic         cen, dir, rot, cout;
  logic [W-1:0] res;

  int checks = 0;
  int fails  = 0;
  exp_t q[$];
  bit done = 0;

  alu_ctrl_decoder #(.WIDTH(W), .OPC_W(3)) dut_i (
    .mode_i(mode), .opcode_i(opc),
    .arith_res_i(ar_res), .logic_res_i(lg_res), .shift_res_i(sh_res),
    .arith_cout_i(ar_cout),
    .arith_opc_o(ao), .logic_opc_o(lo), .shift_opc_o(so),
    .arith_sel_o(asel), .res_sel_o(rsel), .cout_en_o(cen),
    .shift_dir_o(dir), .shift_rot_o(rot),
    .alu_res_o(res), .alu_cout_o(cout));

  // behavioural unit models, driven by the forwarded opcode and controls
  always_comb begin
    logic [W:0] s;
    case (ao[1:0])
      2'b00:   s = {1'b0, a} + {1'b0, b};
      2'b01:   s = {1'b0, a} - {1'b0, b};
      2'b10:   s = {1'b0, a} + 1'b1;
      default: s = {1'b0, a};
    endcase
    ar_res  = s[W-1:0];
    ar_cout = s[W];
    case (lo)
      3'd0: lg_res = ~(a | b);
      3'd1: lg_res = ~(a & b);
      3'd2: lg_res = a | b;
      3'd3: lg_res = a & b;
      3'd4: lg_res = a ^ b;
      3'd5: lg_res = ~(a ^ b);
      3'd6: lg_res = ~a;
      default: lg_res = ~b;
    endcase
    case ({rot, dir})
      2'b00: sh_res = a << b[3:0];
      2'b01: sh_res = a >> b[3:0];
      2'b10: sh_res = (a << b[3:0]) | (a >> (W - b[3:0]));
      default: sh_res = (a >> b[3:0]) | (a << (W - b[3:0]));
    endcase
  end

  function automatic exp_t model(logic m, logic [2:0] o, logic [W-1:0] x, logic [W-1:0] y);
    exp_t e;
    logic [W:0] s;
    e.opc = o; e.asel = 2'b00; e.rsel = 2'b01; e.cen = 0; e.dir = 0; e.rot = 0; e.cout = 0;
    if (!m) begin
      case (o)
        3'd0: e.res = ~(x | y);
        3'd1: e.res = ~(x & y);
        3'd2: e.res = x | y;
        3'd3: e.res = x & y;
        3'd4: e.res = x ^ y;
        3'd5: e.res = ~(x ^ y);
        3'd6: e.res = ~x;
        default: e.res = ~y;
      endcase
    end else if (o < 3'd4) begin
      e.rsel = 2'b00; e.cen = 1; e.asel = o[1:0];
      case (o)
        3'd0: s = {1'b0, x} + {1'b0, y};
        3'd1: s = {1'b0, x} - {1'b0, y};
        3'd2: s = {1'b0, x} + 1'b1;
        default: s = {1'b0, x};
      endcase
      e.res = s[W-1:0]; e.cout = s[W];
    end else begin
      e.rsel = 2'b10;
      case (o)
        3'd4: begin e.res = x << y[3:0]; end
        3'd5: begin e.res = x >> y[3:0]; e.dir = 1; end
        3'd6: begin e.res = (x << y[3:0]) | (x >> (W - y[3:0])); e.rot = 1; end
        default: begin e.res = (x >> y[3:0]) | (x << (W - y[3:0])); e.rot = 1; e.dir = 1; end
      endcase
    end
    return e;
  endfunction

  task automatic drive(logic m, logic [2:0] o, logic [W-1:0] x, logic [W-1:0] y);
    @(posedge clk);
    #1;
    mode = m; opc = o; a = x; b = y;
    q.push_back(model(m, o, x, y));
  endtask

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s mode=%0b opc=%0d actual=%0h expected=%0h", tag, mode, opc, act, exp);
    end
  endtask

  initial begin : monitor
    forever begin
      @(negedge clk);
      if (q.size() != 0) begin
        exp_t e;
        e = q.pop_front();
        chk("R1 opcode forward", {ao, lo, so}, {e.opc, e.opc, e.opc});
        chk("R2/R3/R4 res_sel", rsel, e.rsel);
        chk("R2/R3/R4 cout_en", cen, e.cen);
        chk("R4 shift_dir", dir, e.dir);
        chk("R4 shift_rot", rot, e.rot);
        chk("R3/R7 arith_sel", asel, e.asel);
        chk("R5 alu_cout", cout, e.cout);
        chk("R6 alu_res", res, e.res);
      end
    end
  end

  initial begin : driver
    logic [W-1:0] pa [5];
    logic [W-1:0] pb [5];
    pa[0] = 16'h0000; pb[0] = 16'h0000;
    pa[1] = 16'hFFFF; pb[1] = 16'h0001;
    pa[2] = 16'hA5C3; pb[2] = 16'h3C07;
    pa[3] = 16'h8001; pb[3] = 16'h000F;
    pa[4] = 16'h1234; pb[4] = 16'hF0F4;
    mode = 0; opc = 0; a = 0; b = 0;
    repeat (3) @(posedge clk);
    rst_n = 1'b1;
    for (int p = 0; p < 5; p++)
      for (int m = 0; m < 2; m++)
        for (int o = 0; o < 8; o++)
          drive(m[0], o[2:0], pa[p], pb[p]);
    repeat (3) @(posedge clk);
    done = 1;
  end

  initial begin : watchdog
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog expired");
      end
    join_any
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule